// File: doc/BRIEF.md
# Flow-Through Synchronous Burst RAM

This block models a synchronous static RAM with a flow-through read path and a four-beat burst address generator. Each word is 36 bits wide, organised as four 9-bit lanes (8 data bits plus one parity bit). The depth is set by a parameter. Address, control and write data are captured on the rising clock edge. Read data for the captured address leaves the array through combinational logic in the same cycle, gated by an asynchronous output enable.

A host opens an access with one of two address strobes: a processor-side strobe or a controller-side strobe. Later cycles either step the two low address bits through a linear or interleaved four-beat order, or hold the current address. Three chip enables allow depth expansion. A snooze input freezes the block and keeps the stored data intact. Outputs are plain driven values with a separate drive flag in place of pads.

Top module: `fts_burst_ram`

## Requirements
- R1: While reset is low and in the first idle cycle after it, `rdata` is zero and `rdata_drv` is low.
- R2: An access starts on an edge where `adsc_n` is low, or `adsp_n` is low together with `ce_n` low. If `ce_n` is low, `ce2` is high and (when `THREE_CE` is nonzero) `ce2_n` is low, the full `addr` is loaded and the burst count is cleared. The first beat then uses the loaded address. `adsp_n` low with `ce_n` high is not a start.
- R3: On an edge with no start, during an open access, `adv_n` low moves to the next beat. `adv_n` high keeps the current address, and reads or writes still take place there.
- R4: `order_lin` is captured at the start. When 1, beat k uses low bits (start + k) mod 4. When 0, it uses start XOR k. After four beats the burst wraps. A change of `order_lin` during a burst has no effect.
- R5: A beat writes when `gw_n` is low, which writes all lanes, or when `bwe_n` is low with at least one `bw_n` bit low. In the second case, lane i (bits 9i+8:9i, where lane 0 is bits 8:0) is written when `bw_n[i]` is low. Lanes that are not written keep their contents, and later reads return the written data.
- R6: The first beat of an access started by `adsp_n` is a read, even when the write inputs are asserted.
- R7: A start edge with any chip enable inactive closes the access. That cycle and following non-start cycles neither read nor write.
- R8: Reads are flow-through. Data at the address captured on an edge appears on `rdata` with `rdata_drv` high before the next edge, provided `oe_n` is low.
- R9: `oe_n` high forces `rdata` to zero and `rdata_drv` low immediately, with no clock edge needed.
- R10: While `zz` is high at an edge, that edge starts no access, performs no read or write, and holds the burst address. The stored data is kept. After `zz` falls, an open burst continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, loaded at a start |
| wdata | input | 36 | Write data, captured every edge |
| rdata | output | 36 | Flow-through read data, zero when not driving |
| rdata_drv | output | 1 | High while read data is driven |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Secondary chip enable, active low (ignored when THREE_CE is 0) |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Lane write qualifier, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| zz | input | 1 | Snooze, active high |

## Verification
The bench walks bursts that start at nonzero low bits in both orders and checks the wrap at the fourth beat. A design with the wrong order or a missing wrap would read the wrong word on beats two to four. It asserts the write inputs on a processor-strobe start and checks that no write lands, then writes partial lanes. A design that wrote anyway, or clobbered unselected lanes, would return altered data. It asserts snooze in the middle of a burst with a write pending, pulls the processor strobe while the primary enable is high, and toggles the output enable between edges. A design that did not freeze, that honoured the masked strobe, or that registered the enable would show the wrong address, stray data, or a cycle of delay.

// File: rtl/fts_pkg.sv
// Shared types and helpers for the flow-through burst RAM.
// Assumes a four-beat burst, so the burst count is two bits wide.
package fts_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Low address bits of beat k for a burst that starts at origin.
    function automatic logic [1:0] beat_low(input logic [1:0] origin,
                                            input logic [1:0] k,
                                            input logic       lin);
        logic [1:0] r;
        if (lin) r = origin + k;
        else     r = origin ^ k;
        return r;
    endfunction

endpackage

// File: rtl/fts_burst_seq.sv
// Burst address generator. It holds the start address, the burst order
// and a 2-bit beat count, and forms the current word address from them.
// Assumes ADDR_W > 2. load takes priority over step.
module fts_burst_seq #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_lin,
    output logic [ADDR_W-1:0] cur_addr
);
    import fts_pkg::*;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic              lin_q;

    // Capture the start address and order, or count beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
            lin_q  <= 1'b0;
        end else if (load) begin
            base_q <= ld_addr;
            cnt_q  <= 2'd0;
            lin_q  <= ld_lin;
        end else if (step) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    // Current address: upper bits fixed, low bits per burst order.
    always_comb begin
        cur_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_q, lin_q)};
    end

endmodule

// File: rtl/fts_cycle_ctl.sv
// Cycle decoder. It turns strobes, enables, advance, write controls and
// snooze into a load/step pair for the address generator, and it registers
// the operation, lane mask and write data of each cycle.
// Assumes the write is committed by the array on the edge after capture.
module fts_cycle_ctl #(
    parameter int LANES    = 4,
    parameter int LANE_W   = 9,
    parameter int THREE_CE = 1,
    localparam int DATA_W  = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zz,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce2_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [DATA_W-1:0] wdata,
    output logic              load,
    output logic              step,
    output fts_pkg::op_e      op_q,
    output logic [LANES-1:0]  lanes_q,
    output logic [DATA_W-1:0] wdata_q
);
    import fts_pkg::*;

    logic             sel_ok;
    logic             p_go;
    logic             start;
    logic             wr_req;
    logic [LANES-1:0] wr_lanes;
    logic             active_q;
    op_e              op_next;

    // Decode enables, strobes and the write lane mask.
    always_comb begin
        sel_ok   = !ce_n && ce2 && ((THREE_CE == 0) || !ce2_n);
        p_go     = !adsp_n && !ce_n;
        start    = p_go || !adsc_n;
        if (!gw_n)       wr_lanes = '1;
        else if (!bwe_n) wr_lanes = ~bw_n;
        else             wr_lanes = '0;
        wr_req   = |wr_lanes;
        load     = !zz && start && sel_ok;
        step     = !zz && !start && active_q && !adv_n;
    end

    // Choose the operation of the cycle that starts at the coming edge.
    always_comb begin
        if (zz)
            op_next = OP_IDLE;
        else if (start) begin
            if (!sel_ok)     op_next = OP_IDLE;
            else if (p_go)   op_next = OP_RD;
            else if (wr_req) op_next = OP_WR;
            else             op_next = OP_RD;
        end else if (active_q)
            op_next = wr_req ? OP_WR : OP_RD;
        else
            op_next = OP_IDLE;
    end

    // Track whether an access is open; a start decides open or closed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else if (!zz && start)
            active_q <= sel_ok;
    end

    // Register the operation, lane mask and write data of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_IDLE;
            lanes_q <= '0;
            wdata_q <= '0;
        end else begin
            op_q    <= op_next;
            lanes_q <= wr_lanes;
            wdata_q <= wdata;
        end
    end

endmodule

// File: rtl/fts_lane_array.sv
// Storage built as one memory per byte lane. A registered write is
// committed on the edge after it was captured. Reads are asynchronous.
// Assumes the write address equals the read address of the same cycle.
module fts_lane_array #(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              we,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Commit this lane's slice when its enable is set.
        always_ff @(posedge clk) begin
            if (we && lane_we[g])
                mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[acc_addr];
    end

endmodule

// File: rtl/fts_burst_ram.sv
// Top of the flow-through synchronous burst RAM. It ties the cycle
// decoder, burst address generator and lane storage together, and gates
// the read data with the asynchronous output enable.
// Assumes the lane layout: lane i holds bits 9i+8:9i.
module fts_burst_ram #(
    parameter int ADDR_W   = 8,
    parameter int LANES    = 4,
    parameter int LANE_W   = 9,
    parameter int THREE_CE = 1,
    localparam int DATA_W  = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drv,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce2_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              oe_n,
    input  logic              order_lin,
    input  logic              zz
);
    import fts_pkg::*;

    logic              seq_load;
    logic              seq_step;
    op_e               cyc_op;
    logic [LANES-1:0]  cyc_lanes;
    logic [DATA_W-1:0] cyc_wdata;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] arr_rdata;

    fts_cycle_ctl #(
        .LANES    (LANES),
        .LANE_W   (LANE_W),
        .THREE_CE (THREE_CE)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .zz      (zz),
        .ce_n    (ce_n),
        .ce2     (ce2),
        .ce2_n   (ce2_n),
        .adsp_n  (adsp_n),
        .adsc_n  (adsc_n),
        .adv_n   (adv_n),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .wdata   (wdata),
        .load    (seq_load),
        .step    (seq_step),
        .op_q    (cyc_op),
        .lanes_q (cyc_lanes),
        .wdata_q (cyc_wdata)
    );

    fts_burst_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_load),
        .step     (seq_step),
        .ld_addr  (addr),
        .ld_lin   (order_lin),
        .cur_addr (eff_addr)
    );

    fts_lane_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_arr (
        .clk      (clk),
        .acc_addr (eff_addr),
        .we       (cyc_op == OP_WR),
        .lane_we  (cyc_lanes),
        .wdata    (cyc_wdata),
        .rdata    (arr_rdata)
    );

    // Drive read data only on a read cycle with the output enabled.
    always_comb begin
        rdata_drv = (cyc_op == OP_RD) && !oe_n;
        rdata     = rdata_drv ? arr_rdata : '0;
    end

endmodule

// File: rtl/fts_burst_ram_chk.sv
// Property checker for fts_burst_ram, attached with bind below.
// Assumes the top exposes cyc_op and eff_addr as internal signals.
module fts_burst_ram_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 36,
    parameter int THREE_CE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_drv,
    input logic              ce_n,
    input logic              ce2,
    input logic              ce2_n,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic              zz,
    input logic [1:0]        cyc_op,
    input logic [ADDR_W-1:0] eff_addr
);
    logic sel_ok;
    logic p_go;
    logic start;

    assign sel_ok = !ce_n && ce2 && ((THREE_CE == 0) || !ce2_n);
    assign p_go   = !adsp_n && !ce_n;
    assign start  = p_go || !adsc_n;

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!zz && start && sel_ok)) |-> (eff_addr == $past(addr)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!zz && !start && adv_n)) |-> (eff_addr == $past(eff_addr)));

    assert_adsp_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!zz && p_go && sel_ok)) |-> (cyc_op != fts_pkg::OP_WR));

    assert_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!zz && start && !sel_ok)) |-> (cyc_op == fts_pkg::OP_IDLE && !rdata_drv));

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rdata_drv && rdata == '0));

    assert_snooze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(zz)) |-> (cyc_op == fts_pkg::OP_IDLE && eff_addr == $past(eff_addr)));

endmodule

bind fts_burst_ram fts_burst_ram_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .THREE_CE (THREE_CE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rdata     (rdata),
    .rdata_drv (rdata_drv),
    .ce_n      (ce_n),
    .ce2       (ce2),
    .ce2_n     (ce2_n),
    .adsp_n    (adsp_n),
    .adsc_n    (adsc_n),
    .adv_n     (adv_n),
    .oe_n      (oe_n),
    .zz        (zz),
    .cyc_op    (cyc_op),
    .eff_addr  (eff_addr)
);

// File: tb/sim_fts_burst_ram.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver applies one cycle of inputs, runs a
// behavioural model and queues the expected output; the monitor samples
// 1 ns after each rising edge and compares.
module sim_fts_burst_ram;
    localparam int AW = 8;
    localparam int DW = 36;

    typedef struct {
        logic [DW-1:0] data;
        logic          en;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_drv;
    logic          ce_n = 1'b0, ce2 = 1'b1, ce2_n = 1'b0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          oe_n = 1'b0, order_lin = 1'b1, zz = 1'b0;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    exp_t q[$];

    // Model state
    logic [DW-1:0] mmem [256];
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = 2'd0;
    bit            m_act = 1'b0, m_lin = 1'b0;
    bit            pend_wr = 1'b0;
    logic [AW-1:0] pend_a = '0;
    logic [DW-1:0] pend_d = '0;
    logic [3:0]    pend_ln = '0;
    logic [DW-1:0] last_exp = '0;

    always #2 clk = ~clk;

    fts_burst_ram u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_drv(rdata_drv),
        .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .oe_n(oe_n), .order_lin(order_lin), .zz(zz)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return {4{i[8:0] ^ 9'h0A5}} ^ {i[7:0], 28'h0};
    endfunction

    // Return inputs to a quiet no-strobe cycle.
    task automatic idle();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
        ce_n = 1'b0; ce2 = 1'b1; ce2_n = 1'b0; oe_n = 1'b0; zz = 1'b0;
    endtask

    // Driver: model the coming edge, queue the expectation, pass the edge.
    task automatic tick(input string tag);
        exp_t e;
        bit sel, pgo, start, wreq;
        logic [3:0] ln;
        logic [1:0] lo;
        logic [AW-1:0] eff;
        int op; // 0 idle, 1 read, 2 write
        if (pend_wr)
            for (int i = 0; i < 4; i++)
                if (pend_ln[i]) mmem[pend_a][i*9 +: 9] = pend_d[i*9 +: 9];
        pend_wr = 1'b0;
        sel   = !ce_n && ce2 && !ce2_n;
        pgo   = !adsp_n && !ce_n;
        start = pgo || !adsc_n;
        ln    = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
        wreq  = (ln != 4'h0);
        op = 0;
        if (zz) op = 0;
        else if (start) begin
            if (sel) begin
                m_base = addr; m_cnt = 2'd0; m_lin = order_lin; m_act = 1'b1;
                op = pgo ? 1 : (wreq ? 2 : 1);
            end else begin
                m_act = 1'b0; op = 0;
            end
        end else if (m_act) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            op = wreq ? 2 : 1;
        end
        lo  = m_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
        eff = {m_base[AW-1:2], lo};
        if (op == 2) begin
            pend_wr = 1'b1; pend_a = eff; pend_d = wdata; pend_ln = ln;
        end
        e.en   = (op == 1) && !oe_n;
        e.data = e.en ? mmem[eff] : '0;
        e.tag  = tag;
        last_exp = mmem[eff];
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic c_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        idle(); adsc_n = 1'b0; addr = a; gw_n = 1'b0; wdata = d; tick(tag);
    endtask

    task automatic c_read(input logic [AW-1:0] a, input bit lin, input string tag);
        idle(); adsc_n = 1'b0; addr = a; order_lin = lin; tick(tag);
    endtask

    task automatic beat(input string tag);
        idle(); adv_n = 1'b0; tick(tag);
    endtask

    // Monitor: compare each edge's result against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk((rdata === e.data) && (rdata_drv === e.en), e.tag, rdata, e.data);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mmem[i] = '0;
        // R1: outputs quiet in reset
        repeat (3) @(negedge clk);
        chk(rdata === '0 && rdata_drv === 1'b0, "R1 reset", rdata, '0);
        rst_n = 1'b1;
        idle(); tick("R1 first idle");

        // Preload every word through controller-strobe global writes (R5)
        for (int i = 0; i < 256; i++) c_write(AW'(i), pat(i), "R5 preload");

        // R8/R2: flow-through single read
        c_read(8'h10, 1'b1, "R8 R2 read 0x10");
        c_read(8'h47, 1'b1, "R8 read 0x47");

        // R4 linear from low bits 2 with wrap; mode change mid-burst ignored
        c_read(8'h12, 1'b1, "R4 lin beat0");
        order_lin = 1'b0;
        beat("R4 lin beat1"); beat("R4 lin beat2 wrap");
        beat("R4 lin beat3"); beat("R4 lin beat4 wraps to start");

        // R4 interleaved from low bits 3
        c_read(8'h23, 1'b0, "R4 ilv beat0");
        beat("R4 ilv beat1"); beat("R4 ilv beat2"); beat("R4 ilv beat3");

        // R3 hold with adv high
        c_read(8'h31, 1'b1, "R3 start");
        beat("R3 step");
        idle(); tick("R3 hold 1");
        idle(); tick("R3 hold 2");
        beat("R3 step after hold");

        // R5 lane writes: lanes 0 and 2 only
        idle(); adsc_n = 1'b0; addr = 8'h50; bwe_n = 1'b0; bw_n = 4'b1010;
        wdata = 36'hF_FFFF_FFFF; tick("R5 lane write");
        c_read(8'h50, 1'b1, "R5 lanes kept");
        // bw_n low without bwe_n is no write
        idle(); adsc_n = 1'b0; addr = 8'h51; bw_n = 4'h0; wdata = '0; tick("R5 no bwe read");
        c_read(8'h51, 1'b1, "R5 unchanged");

        // R5 write mid-burst then read back
        c_write(8'h60, 36'h1_2345_6789, "R5 burst w0");
        idle(); adv_n = 1'b0; gw_n = 1'b0; wdata = 36'h9_8765_4321; tick("R5 burst w1");
        c_read(8'h61, 1'b1, "R5 read burst w1");
        c_read(8'h60, 1'b1, "R5 read burst w0");

        // R6 processor strobe with write inputs: read first
        idle(); adsp_n = 1'b0; addr = 8'h70; order_lin = 1'b1; gw_n = 1'b0;
        wdata = 36'h0_DEAD_BEEF; tick("R6 adsp first beat read");
        c_read(8'h70, 1'b1, "R6 word untouched");

        // R2 processor strobe with primary enable high is no start
        c_read(8'h82, 1'b1, "R2 open burst");
        idle(); adsp_n = 1'b0; ce_n = 1'b1; addr = 8'h90; tick("R2 masked adsp holds");

        // R7 deselect via ce2 low, then via ce2_n high
        idle(); adsc_n = 1'b0; ce2 = 1'b0; addr = 8'h11; tick("R7 deselect ce2");
        beat("R7 idle after deselect");
        c_read(8'h15, 1'b1, "R7 reopen");
        idle(); adsc_n = 1'b0; ce2_n = 1'b1; addr = 8'h11; gw_n = 1'b0; tick("R7 deselect ce2_n");
        beat("R7 still idle");
        c_read(8'h11, 1'b1, "R7 no stray write");

        // R10 snooze mid-burst with a write attempt
        c_read(8'hA0, 1'b1, "R10 start");
        beat("R10 beat1");
        idle(); zz = 1'b1; adv_n = 1'b0; adsc_n = 1'b0; addr = 8'hA2;
        gw_n = 1'b0; wdata = '0; tick("R10 snooze ignores");
        idle(); zz = 1'b1; adv_n = 1'b0; tick("R10 snooze holds");
        beat("R10 resume beat2");
        c_read(8'hA2, 1'b1, "R10 contents kept");

        // R9 asynchronous output enable inside a read cycle
        c_read(8'h33, 1'b1, "R9 read");
        oe_n = 1'b1; #0.5;
        chk(rdata === '0 && rdata_drv === 1'b0, "R9 oe high", rdata, '0);
        oe_n = 1'b0; #0.5;
        chk(rdata === last_exp && rdata_drv === 1'b1, "R9 oe low again", rdata, last_exp);
        idle(); oe_n = 1'b1; tick("R9 oe high at edge");

        idle(); tick("end");
        @(posedge clk); #2;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule